// File: doc/BRIEF.md
# Infrared Remote Frame Receiver with System-Code Filter

This block receives pulse-distance infrared remote frames from a demodulated, active-low input that is sampled on the block clock. A mark is a low level and a space is a high level. The block measures every mark and every space in clock cycles and compares each one against tolerance windows. Each window is built from one timing unit, which is a parameter. A full frame has a long leader mark and a long space, then 32 data bits sent least significant bit first, then a closing mark. The data are a 16-bit system field, a command byte and the inverted copy of that command byte. A repeat frame has the same leader mark, then a half-length space, then the closing mark.

A full frame is accepted only when its command byte is the bitwise inverse of the byte that follows it. When system checking is turned on, the 16-bit system field must also equal a programmed value. An accepted full frame loads the code output and clears the repeat flag. An accepted repeat frame keeps the previous code and sets the repeat flag. Both kinds of frame set a sticky interrupt status. The interrupt output is that status gated by a mask input. Software clears the status with an acknowledge pulse.

Top module: `nec_ir_receiver`

## Requirements
- R1: While `ctl_enable` is low the decoder stays idle: frames on `ir_n` change neither `rx_code`, `repeat_flag` nor `irq_status`.
- R2: A full frame has these parts: a mark of 16 units, a space of 8 units, and 32 bits sent least significant bit first. Each bit is a 1-unit mark followed by a space, which is 1 unit for a 0 and 3 units for a 1. A 1-unit closing mark ends the frame. When the frame is accepted, `rx_code[31:16]` holds data bits 15:0 (the system field), `rx_code[15:8]` holds data bits 23:16 (the command) and `rx_code[7:0]` holds data bits 31:24.
- R3: A full frame whose data bits 23:16 are not the bitwise inverse of data bits 31:24 is dropped, and `rx_code` keeps its old value.
- R4: With `ctl_sys_check` high, a full frame is accepted only if data bits 15:0 equal `sys_code`. With it low, any system field is accepted.
- R5: A repeat frame is a 16-unit mark, a 4-unit space and a 1-unit closing mark. It leaves `rx_code` unchanged and sets `repeat_flag` to 1. The next accepted full frame clears `repeat_flag` to 0.
- R6: Every accepted full or repeat frame sets `irq_status` to 1. A one-cycle `irq_ack` pulse clears it. `irq` equals `irq_status` AND `irq_mask`. After reset all outputs are 0.
- R7: A pulse of nominal length N cycles is valid when its length L satisfies N − ⌊N/4⌋ ≤ L ≤ N + ⌊N/4⌋. A pulse outside its window drops the frame.
- R8: The decoder returns to idle after any invalid pulse. It also returns to idle when the line holds one level for 24 units in mid-frame. A correct frame that follows either case is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_n | input | 1 | Demodulated infrared line, low during a mark |
| ctl_enable | input | 1 | Receiver enable |
| ctl_sys_check | input | 1 | Enables the system-field comparison |
| sys_code | input | 16 | Expected system field |
| irq_mask | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the interrupt status |
| rx_code | output | 32 | Last accepted code: system, command, inverted command |
| repeat_flag | output | 1 | Set by a repeat frame |
| irq_status | output | 1 | Sticky frame-received status |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the receiver with `UNIT_CYCLES` = 8. With that value a full frame takes about a thousand cycles, so dozens of random frames fit in the run. Every window edge is a whole number of cycles: a bit mark is valid from 6 to 10 cycles and the leader from 96 to 160. This lets the bench drive pulses exactly one cycle inside and one cycle outside each tested limit. The mid-frame timeout is 192 cycles, which is short enough that a truncated frame followed by a silent gap, and then a good frame, can be run directly.

// File: rtl/nec_rx_pkg.sv
`timescale 1ns/1ps
package nec_rx_pkg;

    localparam int FRAME_BITS  = 32;
    localparam int BIT_IDX_W   = $clog2(FRAME_BITS);
    localparam int NUM_CLASSES = 5;

    // pulse classes, index into the classifier hit vector
    localparam int C_UNIT = 0;  // bit mark, zero space, closing mark
    localparam int C_ONE  = 1;  // one space
    localparam int C_RPT  = 2;  // repeat-frame space
    localparam int C_FULL = 3;  // full-frame space
    localparam int C_LEAD = 4;  // leader mark

    // timeout in units, longer than the widest window
    localparam int STALE_UNITS = 24;

    function automatic int class_units(input int idx);
        case (idx)
            C_UNIT:  return 1;
            C_ONE:   return 3;
            C_RPT:   return 4;
            C_FULL:  return 8;
            default: return 16;
        endcase
    endfunction

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD_MARK,
        S_LEAD_SPACE,
        S_BIT_MARK,
        S_BIT_SPACE,
        S_STOP,
        S_RPT_STOP
    } rx_state_e;

endpackage

// File: rtl/nec_rx_pulse.sv
`timescale 1ns/1ps
module nec_rx_pulse #(
    parameter int CNT_MAX = 192,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_n,
    output logic             pulse_vld,
    output logic             pulse_mark,
    output logic [CNT_W-1:0] pulse_len,
    output logic             stale
);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } pulse_t;

    pulse_t q, d;
    logic   edge_seen;

    always_comb begin
        d         = q;
        d.s1      = ir_n;
        d.s2      = q.s1;
        d.lvl     = q.s2;
        edge_seen = (q.s2 != q.lvl);
        if (edge_seen) begin
            d.cnt = CNT_W'(1);
        end else if (q.cnt != CNT_W'(CNT_MAX)) begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.s1  <= 1'b1;
            q.s2  <= 1'b1;
            q.lvl <= 1'b1;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign pulse_vld  = edge_seen;
    assign pulse_mark = ~q.lvl;
    assign pulse_len  = q.cnt;
    assign stale      = (q.cnt == CNT_W'(CNT_MAX));

endmodule

// File: rtl/nec_rx_classify.sv
`timescale 1ns/1ps
module nec_rx_classify
    import nec_rx_pkg::*;
#(
    parameter int UNIT_CYCLES = 562,
    parameter int CNT_W       = 14
) (
    input  logic [CNT_W-1:0]       len,
    output logic [NUM_CLASSES-1:0] hit
);

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_win
        localparam int NOM = class_units(g) * UNIT_CYCLES;
        localparam int LO  = NOM - NOM / 4;
        localparam int HI  = NOM + NOM / 4;
        assign hit[g] = (len >= CNT_W'(LO)) && (len <= CNT_W'(HI));
    end

endmodule

// File: rtl/nec_rx_frame.sv
`timescale 1ns/1ps
module nec_rx_frame
    import nec_rx_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   sys_check,
    input  logic [15:0]            sys_code,
    input  logic                   pulse_vld,
    input  logic                   pulse_mark,
    input  logic [NUM_CLASSES-1:0] hit,
    input  logic                   stale,
    output logic                   full_ok,
    output logic                   rpt_ok,
    output logic [FRAME_BITS-1:0]  raw
);

    typedef struct packed {
        rx_state_e             st;
        logic [BIT_IDX_W-1:0]  nbits;
        logic [FRAME_BITS-1:0] sh;
        logic                  full_ok;
        logic                  rpt_ok;
    } frm_t;

    frm_t q, d;
    logic cmd_ok;
    logic sys_ok;

    assign cmd_ok = (q.sh[23:16] == ~q.sh[31:24]);
    assign sys_ok = !sys_check || (q.sh[15:0] == sys_code);

    always_comb begin
        d         = q;
        d.full_ok = 1'b0;
        d.rpt_ok  = 1'b0;
        if (!enable) begin
            d.st    = S_IDLE;
            d.nbits = '0;
        end else if (stale && q.st != S_IDLE) begin
            d.st = S_IDLE;
        end else if (pulse_vld) begin
            case (q.st)
                S_IDLE: begin
                    if (!pulse_mark) d.st = S_LEAD_MARK;
                end
                S_LEAD_MARK: begin
                    d.st = (pulse_mark && hit[C_LEAD]) ? S_LEAD_SPACE : S_IDLE;
                end
                S_LEAD_SPACE: begin
                    if (!pulse_mark && hit[C_FULL]) begin
                        d.st    = S_BIT_MARK;
                        d.nbits = '0;
                    end else if (!pulse_mark && hit[C_RPT]) begin
                        d.st = S_RPT_STOP;
                    end else begin
                        d.st = S_IDLE;
                    end
                end
                S_BIT_MARK: begin
                    d.st = (pulse_mark && hit[C_UNIT]) ? S_BIT_SPACE : S_IDLE;
                end
                S_BIT_SPACE: begin
                    if (!pulse_mark && (hit[C_UNIT] || hit[C_ONE])) begin
                        d.sh    = {hit[C_ONE] & ~hit[C_UNIT], q.sh[FRAME_BITS-1:1]};
                        d.nbits = q.nbits + BIT_IDX_W'(1);
                        d.st    = (q.nbits == BIT_IDX_W'(FRAME_BITS - 1)) ? S_STOP : S_BIT_MARK;
                    end else begin
                        d.st = S_IDLE;
                    end
                end
                S_STOP: begin
                    d.full_ok = pulse_mark && hit[C_UNIT] && cmd_ok && sys_ok;
                    d.st      = S_IDLE;
                end
                S_RPT_STOP: begin
                    d.rpt_ok = pulse_mark && hit[C_UNIT];
                    d.st     = S_IDLE;
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= S_IDLE;
            q.nbits   <= '0;
            q.sh      <= '0;
            q.full_ok <= 1'b0;
            q.rpt_ok  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign full_ok = q.full_ok;
    assign rpt_ok  = q.rpt_ok;
    assign raw     = q.sh;

    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (q.st == S_IDLE));

    p_full_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.full_ok |-> $past(q.st == S_STOP));

    p_sys_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full_ok && $past(sys_check)) |-> (q.sh[15:0] == $past(sys_code)));

    p_rpt_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.rpt_ok |-> $past(q.st == S_RPT_STOP));

    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stale && q.st != S_IDLE) |=> (q.st == S_IDLE));

endmodule

// File: rtl/nec_ir_receiver.sv
`timescale 1ns/1ps
module nec_ir_receiver
    import nec_rx_pkg::*;
#(
    parameter int UNIT_CYCLES = 562
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_n,
    input  logic        ctl_enable,
    input  logic        ctl_sys_check,
    input  logic [15:0] sys_code,
    input  logic        irq_mask,
    input  logic        irq_ack,
    output logic [31:0] rx_code,
    output logic        repeat_flag,
    output logic        irq_status,
    output logic        irq
);

    localparam int CNT_MAX = STALE_UNITS * UNIT_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic                   pulse_vld;
    logic                   pulse_mark;
    logic [CNT_W-1:0]       pulse_len;
    logic                   stale;
    logic [NUM_CLASSES-1:0] hit;
    logic                   full_ok;
    logic                   rpt_ok;
    logic [FRAME_BITS-1:0]  raw;

    nec_rx_pulse #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_n       (ir_n),
        .pulse_vld  (pulse_vld),
        .pulse_mark (pulse_mark),
        .pulse_len  (pulse_len),
        .stale      (stale)
    );

    nec_rx_classify #(.UNIT_CYCLES(UNIT_CYCLES), .CNT_W(CNT_W)) u_class (
        .len (pulse_len),
        .hit (hit)
    );

    nec_rx_frame #(.CNT_W(CNT_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctl_enable),
        .sys_check  (ctl_sys_check),
        .sys_code   (sys_code),
        .pulse_vld  (pulse_vld),
        .pulse_mark (pulse_mark),
        .hit        (hit),
        .stale      (stale),
        .full_ok    (full_ok),
        .rpt_ok     (rpt_ok),
        .raw        (raw)
    );

    typedef struct packed {
        logic [31:0] code;
        logic        rpt;
        logic        status;
    } out_t;

    out_t q, d;

    always_comb begin
        d = q;
        if (full_ok) begin
            d.code   = {raw[15:0], raw[23:16], raw[31:24]};
            d.rpt    = 1'b0;
            d.status = 1'b1;
        end else if (rpt_ok) begin
            d.rpt    = 1'b1;
            d.status = 1'b1;
        end else if (irq_ack) begin
            d.status = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_code     = q.code;
    assign repeat_flag = q.rpt;
    assign irq_status  = q.status;
    assign irq         = q.status & irq_mask;

    p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_enable && $past(!ctl_enable)) |=> $stable(q.code));

    p_cmd_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.code) |-> (q.code[15:8] == ~q.code[7:0]));

    p_rpt_keeps_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rpt) |-> $stable(q.code));

    p_status_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.status) |-> $past(full_ok || rpt_ok));

endmodule

// File: tb/tb_nec_ir_receiver.sv
`timescale 1ns/1ps
module tb_nec_ir_receiver;

    localparam int U = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_n = 1'b1;
    logic        ctl_enable = 1'b0;
    logic        ctl_sys_check = 1'b0;
    logic [15:0] sys_code = '0;
    logic        irq_mask = 1'b0;
    logic        irq_ack = 1'b0;
    logic [31:0] rx_code;
    logic        repeat_flag;
    logic        irq_status;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] exp_code = '0;
    logic        exp_rpt  = 1'b0;
    logic        exp_st   = 1'b0;

    always #2.5 clk = ~clk;

    nec_ir_receiver #(.UNIT_CYCLES(U)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ir_n          (ir_n),
        .ctl_enable    (ctl_enable),
        .ctl_sys_check (ctl_sys_check),
        .sys_code      (sys_code),
        .irq_mask      (irq_mask),
        .irq_ack       (irq_ack),
        .rx_code       (rx_code),
        .repeat_flag   (repeat_flag),
        .irq_status    (irq_status),
        .irq           (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " code"}, rx_code, exp_code);
        chk({tag, " repeat"}, {31'd0, repeat_flag}, {31'd0, exp_rpt});
        chk({tag, " status"}, {31'd0, irq_status}, {31'd0, exp_st});
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, exp_st & irq_mask});
    endtask

    task automatic hold(input logic lvl, input int n);
        ir_n = lvl;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_raw(input logic [15:0] sys, input logic [7:0] cmd,
                                           input logic [7:0] inv);
        return {inv, cmd, sys};
    endfunction

    function automatic logic [31:0] code_of(input logic [31:0] raw);
        return {raw[15:0], raw[23:16], raw[31:24]};
    endfunction

    // full frame; bad_idx selects one bit mark of length bad_len, cut stops after cut bits
    task automatic send_frame(input logic [31:0] raw, input int lead_len,
                              input int bad_idx, input int bad_len, input int cut);
        hold(1'b0, lead_len);
        hold(1'b1, 8 * U);
        for (int i = 0; i < 32; i++) begin
            if (i == cut) begin
                hold(1'b1, 30 * U);
                return;
            end
            hold(1'b0, (i == bad_idx) ? bad_len : U);
            hold(1'b1, raw[i] ? 3 * U : U);
        end
        hold(1'b0, U);
        hold(1'b1, 40);
    endtask

    task automatic send_good(input logic [31:0] raw);
        send_frame(raw, 16 * U, -1, 0, 99);
    endtask

    task automatic send_repeat();
        hold(1'b0, 16 * U);
        hold(1'b1, 4 * U);
        hold(1'b0, U);
        hold(1'b1, 40);
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        @(negedge clk);
        exp_st = 1'b0;
    endtask

    function automatic bit accepts(input logic [31:0] raw);
        return (raw[23:16] == ~raw[31:24]) && (!ctl_sys_check || raw[15:0] == sys_code);
    endfunction

    initial begin
        #950000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] raw;
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R6 reset");

        ctl_enable = 1'b1;
        irq_mask   = 1'b1;
        repeat (4) @(negedge clk);

        // R2 directed full frame
        raw = mk_raw(16'hA55A, 8'h3C, 8'hC3);
        send_good(raw);
        exp_code = code_of(raw); exp_st = 1'b1;
        chk_all("R2 full frame");
        chk("R2 command field", {24'd0, rx_code[15:8]}, 32'h3C);

        ack();
        chk_all("R6 ack clears");

        // R5 repeat
        send_repeat();
        exp_rpt = 1'b1; exp_st = 1'b1;
        chk_all("R5 repeat keeps code");
        raw = mk_raw(16'h0102, 8'h81, 8'h7E);
        send_good(raw);
        exp_code = code_of(raw); exp_rpt = 1'b0;
        chk_all("R5 full frame clears repeat");
        ack();

        // R3 integrity
        send_good(mk_raw(16'h1111, 8'h22, 8'h22));
        chk_all("R3 bad complement dropped");

        // R4 system check
        ctl_sys_check = 1'b1; sys_code = 16'hBEEF;
        send_good(mk_raw(16'hBEEE, 8'h10, 8'hEF));
        chk_all("R4 system mismatch dropped");
        raw = mk_raw(16'hBEEF, 8'h10, 8'hEF);
        send_good(raw);
        exp_code = code_of(raw); exp_st = 1'b1;
        chk_all("R4 system match accepted");
        ctl_sys_check = 1'b0;
        ack();

        // R1 disabled
        ctl_enable = 1'b0;
        send_good(mk_raw(16'h7777, 8'h55, 8'hAA));
        send_repeat();
        chk_all("R1 disabled ignores frames");
        ctl_enable = 1'b1;
        repeat (4) @(negedge clk);

        // R7 tolerance windows
        raw = mk_raw(16'h2222, 8'h01, 8'hFE);
        send_frame(raw, 96, -1, 0, 99);
        exp_code = code_of(raw); exp_st = 1'b1;
        chk_all("R7 leader at lower limit");
        ack();
        send_frame(mk_raw(16'h3333, 8'h02, 8'hFD), 95, -1, 0, 99);
        chk_all("R7 leader below limit dropped");
        raw = mk_raw(16'h4444, 8'h03, 8'hFC);
        send_frame(raw, 16 * U, 5, 10, 99);
        exp_code = code_of(raw); exp_st = 1'b1;
        chk_all("R7 bit mark at upper limit");
        ack();
        send_frame(mk_raw(16'h5555, 8'h04, 8'hFB), 16 * U, 5, 11, 99);
        chk_all("R7 bit mark above limit dropped");
        raw = mk_raw(16'h6666, 8'h05, 8'hFA);
        send_frame(raw, 160, 7, 6, 99);
        exp_code = code_of(raw); exp_st = 1'b1;
        chk_all("R7 leader upper and mark lower limit");
        ack();
        send_frame(mk_raw(16'h6667, 8'h06, 8'hF9), 16 * U, 7, 5, 99);
        chk_all("R7 bit mark below limit dropped");

        // R8 recovery
        send_frame(mk_raw(16'h9999, 8'h07, 8'hF8), 16 * U, -1, 0, 10);
        raw = mk_raw(16'h8888, 8'h08, 8'hF7);
        send_good(raw);
        exp_code = code_of(raw); exp_st = 1'b1;
        chk_all("R8 recovers after truncated frame");
        ack();
        send_frame(mk_raw(16'hAAAA, 8'h09, 8'hF6), 16 * U, 3, 20, 99);
        raw = mk_raw(16'hCCCC, 8'h0A, 8'hF5);
        send_good(raw);
        exp_code = code_of(raw); exp_st = 1'b1;
        chk_all("R8 recovers after bad pulse");

        // R6 mask
        irq_mask = 1'b0;
        @(negedge clk);
        chk_all("R6 masked irq");
        irq_mask = 1'b1;
        ack();

        // random frames, R2 R3 R4 R5 R6
        for (int k = 0; k < 30; k++) begin
            logic [15:0] sys;
            logic [7:0]  cmd;
            logic [7:0]  inv;
            sys = 16'($urandom);
            cmd = 8'($urandom);
            inv = ($urandom % 4 == 0) ? 8'($urandom) : ~cmd;
            ctl_sys_check = 1'($urandom % 2);
            sys_code = ($urandom % 2 == 0) ? sys : (sys ^ 16'h0100);
            irq_mask = 1'($urandom % 2);
            raw = mk_raw(sys, cmd, inv);
            send_good(raw);
            if (accepts(raw)) begin
                exp_code = code_of(raw); exp_rpt = 1'b0; exp_st = 1'b1;
            end
            chk_all("R4 R3 random frame");
            if ($urandom % 5 == 0) begin
                send_repeat();
                exp_rpt = 1'b1; exp_st = 1'b1;
                chk_all("R5 random repeat");
            end
            if ($urandom % 2 == 0) begin
                ack();
                chk_all("R6 random ack");
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule